// File: doc/BRIEF.md
# Four-Floor Lift Controller

This block controls a single lift car serving four landings, numbered 0 (ground) to 3. Call buttons outside the car (hall calls) and inside the car (car calls) arrive as one bit per floor. The controller latches them, chooses a direction, and runs the motor until the car reaches a requested landing. It then stops the car, holds the door open for a fixed time and closes it before the car moves again. An 8-bit position sensor tells the controller where the car is. The controller reduces that reading to one of seven position codes: four at a landing and three in the gaps between adjacent landings.

The controller works as a travel-direction sweep. The car keeps moving in its present direction while any request lies ahead of it. When none remain ahead, it turns round or comes to rest. An overload input keeps the door open and sounds a chime while the door is open. It also keeps a closed car from leaving. A one-hot floor lamp shows the last landing the car reached. All pins are plain level signals. A call is a single-cycle pulse that the controller captures, so the block never applies back-pressure.

Top module: `lift_ctrl`

## Requirements
- R1: A synchronous reset, active high, places the controller at rest at ground. After reset the door is closed, the motor is stopped, nothing is pending, `floor_lamp` is 4'b0001 and `chime` is low. The car stays at rest while no call arrives.
- R2: The sensor reading p decodes to landing k when p equals k*FLOOR_SPAN (default 64). It decodes to the gap above landing k when p lies strictly between k*FLOOR_SPAN and (k+1)*FLOOR_SPAN. Any reading at or above the top landing's value decodes to the top landing.
- R3: A call on `call_hall` or `call_car` (bit k = landing k), held for one cycle, is latched at the next clock edge. If the call is for another landing, `motor_run` rises on the following edge. `motor_up` is 1 when the target lies above the car and 0 when it lies below.
- R4: A pending landing stops the car when the sensor reaches it. The car is then at rest at that landing's sensor value, `door_open` is 1 and `floor_lamp` shows that landing.
- R5: The car passes a landing that has no pending request and keeps `motor_run` at 1.
- R6: The car keeps its direction while requests remain ahead. Only after serving those does it reverse toward requests behind it.
- R7: Without overload, `door_open` stays high for exactly DOOR_CYCLES (default 16) cycles. The car departs no earlier than the edge after the door has closed.
- R8: A call for the landing where the car rests with the door closed opens the door without any motion. The door opens on the second edge after the call.
- R9: A call for the landing whose door is open is absorbed. The door closes on schedule and does not open again.
- R10: While `overload` is high and the door is open, the door stays open, `chime` is 1 and the car does not move. The door closes on the DOOR_CYCLES-th edge after the last edge at which `overload` was high.
- R11: While `overload` is high and the door is closed, the car does not depart and `chime` stays 0. The car departs on the first edge after `overload` falls.
- R12: `floor_lamp` is one-hot, with bit k for landing k. It shows the last landing the sensor reached and holds that value while the car is in a gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| call_hall | input | 4 | Landing call buttons, bit k = landing k |
| call_car | input | 4 | In-car destination buttons, bit k = landing k |
| pos_sense | input | 8 | Fine car position reading |
| overload | input | 1 | Car weight above limit |
| motor_up | output | 1 | Travel direction, 1 = up |
| motor_run | output | 1 | 1 = motor driving, 0 = car held |
| door_open | output | 1 | 1 = door open, 0 = door closed |
| floor_lamp | output | 4 | One-hot landing indicator |
| chime | output | 1 | Overload warning sound |

## Verification
A plant model in the bench moves the sensor 16 counts per cycle while the motor runs. The expected landing of each door opening is queued when the call is made and compared when the door opens. The service order is exercised with three kinds of call. A single distant call separates a stop at the target from a stop at an intermediate landing. Calls above and below the car, pressed together, separate direction keeping from nearest-first or lowest-first service. A call at the current landing separates opening in place from a spurious trip. Overload is applied once with the door open and once with it closed, which separates the timer restart from a timer that merely pauses. A final jump of the sensor above the top landing exercises the clamp in the decoder.

// File: rtl/lift_pkg.sv
package lift_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DOOR = 2'd2
  } lift_state_e;

  function automatic int idx_width(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/lift_pos_decode.sv
module lift_pos_decode
  import lift_pkg::*;
#(
  parameter int NUM_FLOORS = 4,
  parameter int POS_W      = 8,
  parameter int FLOOR_SPAN = 64
) (
  input  logic [POS_W-1:0]                     pos_raw,
  input  logic                                 clk,
  input  logic                                 rst,
  output logic [idx_width(2*NUM_FLOORS-1)-1:0] pos_code,
  output logic                                 at_floor,
  output logic [idx_width(NUM_FLOORS)-1:0]     floor_idx
);
  localparam int NUM_POS = 2 * NUM_FLOORS - 1;
  localparam int PC_W    = idx_width(NUM_POS);
  localparam int FL_W    = idx_width(NUM_FLOORS);
  localparam int SPAN_SH = $clog2(FLOOR_SPAN);
  localparam logic [POS_W-1:0] TOP_COARSE = POS_W'(NUM_FLOORS - 1);
  localparam logic [PC_W-1:0]  TOP_CODE   = PC_W'(NUM_POS - 1);

  logic [POS_W-1:0]   coarse;
  logic [SPAN_SH-1:0] fine;

  assign coarse = pos_raw >> SPAN_SH;
  assign fine   = pos_raw[SPAN_SH-1:0];

  always_comb begin
    if (coarse >= TOP_COARSE) begin
      pos_code = TOP_CODE;
    end else begin
      pos_code = PC_W'({coarse, 1'b0}) | PC_W'(|fine);
    end
  end

  assign at_floor  = ~pos_code[0];
  assign floor_idx = FL_W'(pos_code >> 1);

  // R2: a landing code is only produced on an exact landing value or above the top
  a_r2_landing_exact: assert property (@(posedge clk) disable iff (rst)
    at_floor |-> ((fine == '0) || (coarse >= TOP_COARSE)));
endmodule

// File: rtl/lift_requests.sv
module lift_requests
  import lift_pkg::*;
#(
  parameter int NUM_FLOORS = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_FLOORS-1:0]             call_in,
  input  logic                              clr_en,
  input  logic [idx_width(NUM_FLOORS)-1:0]  clr_idx,
  input  logic [idx_width(NUM_FLOORS)-1:0]  cur_idx,
  output logic [NUM_FLOORS-1:0]             pend,
  output logic                              here,
  output logic                              above,
  output logic                              below
);
  localparam int FL_W = idx_width(NUM_FLOORS);

  logic [NUM_FLOORS-1:0] clr_mask;
  logic [NUM_FLOORS-1:0] above_v;
  logic [NUM_FLOORS-1:0] below_v;

  assign clr_mask = clr_en ? (NUM_FLOORS'(1) << clr_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
    end else begin
      pend <= (pend | call_in) & ~clr_mask;
    end
  end

  for (genvar i = 0; i < NUM_FLOORS; i++) begin : g_dir
    assign above_v[i] = pend[i] && (FL_W'(i) > cur_idx);
    assign below_v[i] = pend[i] && (FL_W'(i) < cur_idx);
  end

  assign above = |above_v;
  assign below = |below_v;
  assign here  = pend[cur_idx];

  // R9: a landing served with the door open holds no request afterwards
  a_r9_served_cleared: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> !pend[$past(clr_idx)]);
endmodule

// File: rtl/lift_door_timer.sv
module lift_door_timer #(
  parameter int DOOR_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic hold,
  output logic done
);
  localparam int CNT_W = (DOOR_CYCLES > 1) ? $clog2(DOOR_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DOOR_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run || hold) begin
      cnt <= '0;
    end else if (cnt != LAST) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign done = run && !hold && (cnt == LAST);

  // R10: the hold input restarts the open time from zero
  a_r10_hold_restarts: assert property (@(posedge clk) disable iff (rst)
    hold |=> (cnt == '0));
  // R7: the count never passes the configured open time
  a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/lift_ctrl.sv
module lift_ctrl
  import lift_pkg::*;
#(
  parameter int NUM_FLOORS  = 4,
  parameter int POS_W       = 8,
  parameter int FLOOR_SPAN  = 64,
  parameter int DOOR_CYCLES = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_FLOORS-1:0] call_hall,
  input  logic [NUM_FLOORS-1:0] call_car,
  input  logic [POS_W-1:0]      pos_sense,
  input  logic                  overload,
  output logic                  motor_up,
  output logic                  motor_run,
  output logic                  door_open,
  output logic [NUM_FLOORS-1:0] floor_lamp,
  output logic                  chime
);
  localparam int NUM_POS = 2 * NUM_FLOORS - 1;
  localparam int PC_W    = idx_width(NUM_POS);
  localparam int FL_W    = idx_width(NUM_FLOORS);

  lift_state_e           state;
  logic                  dir_up;
  logic [PC_W-1:0]       pos_code;
  logic [PC_W-1:0]       pos_q;
  logic                  at_floor;
  logic [FL_W-1:0]       cur_idx;
  logic [FL_W-1:0]       lamp_idx;
  logic [NUM_FLOORS-1:0] pend;
  logic                  here;
  logic                  above;
  logic                  below;
  logic                  door_done;
  logic                  in_door;
  logic                  arrive;
  logic                  keep_going;
  logic                  want_up;
  logic                  want_down;

  assign in_door = (state == ST_DOOR);

  lift_pos_decode #(
    .NUM_FLOORS(NUM_FLOORS), .POS_W(POS_W), .FLOOR_SPAN(FLOOR_SPAN)
  ) u_decode (
    .pos_raw  (pos_sense),
    .clk      (clk),
    .rst      (rst),
    .pos_code (pos_code),
    .at_floor (at_floor),
    .floor_idx(cur_idx)
  );

  lift_requests #(.NUM_FLOORS(NUM_FLOORS)) u_req (
    .clk    (clk),
    .rst    (rst),
    .call_in(call_hall | call_car),
    .clr_en (in_door),
    .clr_idx(cur_idx),
    .cur_idx(cur_idx),
    .pend   (pend),
    .here   (here),
    .above  (above),
    .below  (below)
  );

  lift_door_timer #(.DOOR_CYCLES(DOOR_CYCLES)) u_door (
    .clk (clk),
    .rst (rst),
    .run (in_door),
    .hold(overload),
    .done(door_done)
  );

  // a landing reached straight from a gap counts as an arrival
  assign arrive     = at_floor && pos_q[0];
  assign keep_going = dir_up ? above : below;
  assign want_up    = above && (dir_up || !below);
  assign want_down  = below && (!dir_up || !above);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      dir_up   <= 1'b1;
      pos_q    <= '0;
      lamp_idx <= '0;
    end else begin
      pos_q <= pos_code;
      if (at_floor) begin
        lamp_idx <= cur_idx;
      end
      unique case (state)
        ST_IDLE: begin
          if (!overload) begin
            if (here) begin
              state <= ST_DOOR;
            end else if (want_up) begin
              dir_up <= 1'b1;
              state  <= ST_RUN;
            end else if (want_down) begin
              dir_up <= 1'b0;
              state  <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (arrive) begin
            if (here) begin
              state <= ST_DOOR;
            end else if (!keep_going) begin
              state <= ST_IDLE;
            end
          end
        end
        ST_DOOR: begin
          if (door_done) begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign motor_run = (state == ST_RUN);
  assign motor_up  = dir_up;
  assign door_open = in_door;
  assign chime     = in_door && overload;

  for (genvar k = 0; k < NUM_FLOORS; k++) begin : g_lamp
    assign floor_lamp[k] = (lamp_idx == FL_W'(k));
  end

  // R7: motion only ever starts from the closed, resting state
  a_r7_depart_closed: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && $past(state) != ST_RUN) |-> ($past(state) == ST_IDLE));
  // R4: the door is only open while the sensor reads a landing
  a_r4_door_at_landing: assert property (@(posedge clk) disable iff (rst)
    in_door |-> at_floor);
  // R10: overload with the door open keeps it open
  a_r10_door_held: assert property (@(posedge clk) disable iff (rst)
    (in_door && overload) |=> in_door);
  // R11: overload with the door closed prevents departure
  a_r11_no_depart: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && overload) |=> (state != ST_RUN));
  // R12: the lamp holds while the car is between landings
  a_r12_lamp_holds: assert property (@(posedge clk) disable iff (rst)
    !at_floor |=> $stable(lamp_idx));
endmodule

// File: tb/lift_ctrl_test.sv
module lift_ctrl_test;
  localparam int SPAN = 64;
  localparam int STEP = 16;
  localparam int DOOR = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] call_hall = '0;
  logic [3:0] call_car = '0;
  logic [7:0] pos = '0;
  logic       overload = 1'b0;
  logic       motor_up, motor_run, door_open, chime;
  logic [3:0] floor_lamp;
  logic       jump_en = 1'b0;
  logic [7:0] jump_val = '0;

  int checks = 0;
  int failures = 0;
  int exp_q[$];

  always #2 clk = ~clk;

  lift_ctrl uut (
    .clk(clk), .rst(rst), .call_hall(call_hall), .call_car(call_car),
    .pos_sense(pos), .overload(overload), .motor_up(motor_up),
    .motor_run(motor_run), .door_open(door_open), .floor_lamp(floor_lamp),
    .chime(chime)
  );

  // plant model: the car moves one step per cycle while the motor runs
  always @(negedge clk) begin
    if (rst) pos <= '0;
    else if (jump_en) pos <= jump_val;
    else if (motor_run) pos <= motor_up ? pos + 8'(STEP) : pos - 8'(STEP);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic press(input logic [3:0] h, input logic [3:0] c);
    call_hall = h;
    call_car  = c;
    tick();
    call_hall = '0;
    call_car  = '0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 4) begin
      tick();
      if (!motor_run && !door_open) quiet++;
      else quiet = 0;
    end
  endtask

  // monitor: pops the expected landing on every door opening
  logic prev_door = 1'b0;
  int   open_len = 0;
  bit   ow_seen = 1'b0;
  int   f_exp;
  always @(posedge clk) begin
    #1;
    if (rst) begin
      prev_door = 1'b0;
    end else begin
      if (door_open && !prev_door) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected door opening, lamp", int'(floor_lamp), 0);
        end else begin
          f_exp = exp_q.pop_front();
          chk(floor_lamp == (4'b0001 << f_exp), "R4", "lamp at door opening",
              int'(floor_lamp), 1 << f_exp);
          chk(!motor_run && ((int'(pos) == f_exp * SPAN) || (f_exp == 3 && int'(pos) >= 3 * SPAN)),
              "R4", "stop position", int'(pos), f_exp * SPAN);
        end
        open_len = 0;
        ow_seen  = 1'b0;
      end
      if (door_open) begin
        open_len++;
        if (overload) ow_seen = 1'b1;
      end
      if (!door_open && prev_door && !ow_seen)
        chk(open_len == DOOR, "R7", "door open cycles", open_len, DOOR);
      prev_door = door_open;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit ok;
    tick(3);
    rst = 1'b0;
    tick();
    // R1 reset state
    chk(!motor_run && !door_open, "R1", "motion/door after reset", {motor_run, door_open}, 0);
    chk(floor_lamp == 4'b0001, "R1", "lamp after reset", int'(floor_lamp), 1);
    chk(!chime, "R1", "chime after reset", int'(chime), 0);
    tick(5);
    chk(!motor_run && !door_open, "R1", "rest with no calls", {motor_run, door_open}, 0);

    // R3 single distant call
    exp_q.push_back(2);
    press(4'b0100, 4'b0000);
    chk(!motor_run, "R3", "motor before second edge", int'(motor_run), 0);
    tick();
    chk(motor_run && motor_up, "R3", "start upward", {motor_run, motor_up}, 3);

    // R5 / R2 pass landing 1
    while (pos != 8'(SPAN)) tick();
    chk(motor_run, "R5", "passing unrequested landing", int'(motor_run), 1);
    chk(floor_lamp == 4'b0010, "R2", "landing 1 decoded", int'(floor_lamp), 2);

    while (!door_open) tick();
    // R6 / R9 calls above and below, plus the open landing
    exp_q.push_back(3);
    exp_q.push_back(0);
    press(4'b1000, 4'b0101);
    while (door_open) tick();
    tick();
    chk(motor_run && motor_up, "R6", "keeps upward direction", {motor_run, motor_up}, 3);
    while (!door_open) tick();
    while (!motor_run) tick();
    chk(!motor_up, "R6", "reverses after top served", int'(motor_up), 0);
    while (pos != 8'(3 * SPAN - STEP)) tick();
    chk(floor_lamp == 4'b1000, "R12", "lamp holds in gap", int'(floor_lamp), 8);
    while (pos != 8'(2 * SPAN)) tick();
    chk(motor_run && floor_lamp == 4'b0100, "R5", "pass landing 2 downward",
        {motor_run, floor_lamp}, 20);
    wait_idle();
    chk(pos == 8'd0, "R6", "ends at ground", int'(pos), 0);
    chk(exp_q.size() == 0, "R9", "all expected openings seen", exp_q.size(), 0);

    // R8 call at the resting landing
    exp_q.push_back(0);
    press(4'b0001, 4'b0000);
    chk(!door_open, "R8", "door before second edge", int'(door_open), 0);
    tick();
    chk(door_open && !motor_run, "R8", "opens in place", {door_open, motor_run}, 2);

    // R10 overload with door open
    tick(3);
    overload = 1'b1;
    tick();
    chk(chime && door_open, "R10", "chime with door open", {chime, door_open}, 3);
    exp_q.push_back(1);
    press(4'b0000, 4'b0010);
    ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick();
      if (!door_open || motor_run || !chime) ok = 1'b0;
    end
    chk(ok, "R10", "door held under overload", int'(ok), 1);
    overload = 1'b0;
    ok = 1'b1;
    for (int i = 1; i < DOOR; i++) begin
      tick();
      if (!door_open) ok = 1'b0;
    end
    chk(ok && !chime, "R10", "open time restarted", int'(ok), 1);
    tick();
    chk(!door_open && !motor_run, "R10", "closes after full time", {door_open, motor_run}, 0);
    tick();
    chk(motor_run && motor_up, "R7", "departs after close", {motor_run, motor_up}, 3);
    wait_idle();

    // R11 overload with door closed
    overload = 1'b1;
    press(4'b1000, 4'b0000);
    ok = 1'b1;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (motor_run || door_open || chime) ok = 1'b0;
    end
    chk(ok, "R11", "no departure under overload", int'(ok), 1);
    exp_q.push_back(3);
    overload = 1'b0;
    tick();
    chk(motor_run && motor_up, "R11", "departs once overload clears", {motor_run, motor_up}, 3);
    wait_idle();

    // R2 clamp above the top landing
    jump_en  = 1'b1;
    jump_val = 8'd224;
    tick();
    jump_en = 1'b0;
    tick();
    exp_q.push_back(3);
    press(4'b1000, 4'b0000);
    tick();
    chk(door_open && !motor_run, "R2", "top clamp treated as landing", {door_open, motor_run}, 2);
    chk(floor_lamp == 4'b1000, "R2", "lamp at clamp", int'(floor_lamp), 8);
    wait_idle();
    chk(exp_q.size() == 0, "R4", "queue drained", exp_q.size(), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule